// File: doc/BRIEF.md
# Exception Entry and Privileged Return Sequencer

This block runs the memory steps a small 16-bit processor needs for exceptions and for returning from them. An exception comes from a general request line with a vector index, or from a dedicated divide-by-zero line. When one is taken, the block pushes the interrupted status word and program counter onto the stack. It then reads a fresh program counter and status word from the vector table. The privilege mode comes from the loaded status word, so a handler can keep running at user level and need not enter the kernel.

The return strobe works the other way round. It pops the program counter and status word from the stack and checks that the mode being restored is no more privileged than the mode that issued the return. A return that fails the check does not change the mode. Instead it enters a fixed privilege-fault vector, and that vector always runs in kernel mode. The block also screens ordinary data stores, so that user code can never write into the vector table.

The processor loads the `new_*` outputs in the cycle in which `upd` is high. It must not present another return or store while `busy` is high.

Top module: `trap_sequencer`

## Requirements
- R1: Taking vector i reads the new program counter from byte address 4*i and the new status word from 4*i+2. The privilege mode, in status bits [15:14], is taken from the loaded word. The encoding is 00 kernel, 01 supervisor and 11 user. For the fault vector FLT_VEC (default 1), bits [15:14] are forced to 00.
- R2: On entry, the old status word is written at sp-2 and the old program counter at sp-4, and `new_sp` becomes sp-4.
- R3: A return is accepted in any mode. It reads the program counter from sp and the status word from sp+2, and `new_sp` becomes sp+4.
- R4: A return succeeds only if the restored mode is not 10 and is numerically greater than or equal to the current mode. Kernel may restore any valid mode, supervisor may restore supervisor or user, and user may restore only user.
- R5: A failed return pulses `priv_fault` for one cycle. It then performs a full entry through FLT_VEC from the original sp, pushing the status word and program counter that were current when the return was issued.
- R6: When the current mode is user (11), a store to a byte address below 4*NVEC produces no memory write and pulses `wr_denied`. Any other store is written to memory.
- R7: `dz_req` vectors through DZ_VEC (default 2). It takes priority over `exc_req` in the same cycle, and the `exc_req` from that cycle is held.
- R8: An exception request that arrives while the block is busy, or that loses to a higher-priority request, is held in a one-deep slot. It is taken in the cycle after the current sequence ends.
- R9: After reset, `busy`, `upd`, `priv_fault` and `wr_denied` are low and the `new_*` outputs are zero. `busy` stays high from the first cycle of a sequence through its single-cycle `upd` pulse.
- R10: A memory access keeps its address and request stable until `mem_rdy` is high. The results do not depend on how many wait cycles are inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request pulse |
| exc_idx | input | IW | Vector index for exc_req |
| dz_req | input | 1 | Divide-by-zero request pulse |
| rti_req | input | 1 | Return-from-exception strobe |
| st_req | input | 1 | Data store request |
| st_addr | input | 16 | Store byte address |
| st_data | input | 16 | Store data |
| cur_pc | input | 16 | Current program counter |
| cur_psw | input | 16 | Current status word, mode in [15:14] |
| cur_sp | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory access complete |
| new_pc | output | 16 | Program counter to load |
| new_psw | output | 16 | Status word to load |
| new_sp | output | 16 | Stack pointer to load |
| upd | output | 1 | One-cycle pulse: load the new_* values |
| busy | output | 1 | Sequence in progress |
| priv_fault | output | 1 | Pulse on a refused return |
| wr_denied | output | 1 | Pulse on a blocked user store |

## Verification
The hardest case to reach is a held request. It needs a second exception to arrive while the stack and vector accesses are still stalled, so that it must be taken from the slot once the first sequence completes. The bench gets there in two ways. It fires the divide-by-zero line and the general line in the same cycle, and it fires a second request two cycles into a sequence, with random memory wait states active throughout. Before the held request is taken, the bench loads the first sequence's results as the processor context. The second stack frame must therefore sit directly below the first.

// File: rtl/trap_sequencer.sv
module trap_sequencer #(
  parameter int NVEC    = 8,
  parameter int FLT_VEC = 1,
  parameter int DZ_VEC  = 2,
  parameter int IW      = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req,
  input  logic [IW-1:0] exc_idx,
  input  logic          dz_req,
  input  logic          rti_req,
  input  logic          st_req,
  input  logic [15:0]   st_addr,
  input  logic [15:0]   st_data,
  input  logic [15:0]   cur_pc,
  input  logic [15:0]   cur_psw,
  input  logic [15:0]   cur_sp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [15:0]   mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_rdy,
  output logic [15:0]   new_pc,
  output logic [15:0]   new_psw,
  output logic [15:0]   new_sp,
  output logic          upd,
  output logic          busy,
  output logic          priv_fault,
  output logic          wr_denied
);
  localparam logic [15:0] VT_END = 16'(4 * NVEC);
  localparam logic [1:0]  M_USR  = 2'b11;
  localparam logic [1:0]  M_BAD  = 2'b10;

  typedef enum logic [3:0] {
    S_IDLE, S_PSHS, S_PSHP, S_VPC, S_VPS, S_POPP, S_POPS, S_DONE, S_STW
  } state_t;

  state_t        st;
  logic [15:0]   pc_r, psw_r, sp_r, sp0, opc, opsw, stw_a, stw_d;
  logic [IW-1:0] vec_r, pend_idx;
  logic [1:0]    m0, stw_m;
  logic          pend, is_ret, faulted, fault_q, deny_q;

  wire idle     = (st == S_IDLE);
  wire start_x  = idle & (pend | dz_req | exc_req);
  wire start_r  = idle & ~start_x & rti_req;
  wire start_s  = idle & ~start_x & ~rti_req & st_req;
  wire st_block = (cur_psw[15:14] == M_USR) && (st_addr < VT_END);
  wire keep_d   = dz_req & ~(idle & ~pend);
  wire keep_e   = exc_req & ~(idle & ~pend & ~dz_req);
  wire pend_ok  = ~pend | idle;
  wire [IW-1:0] take_idx = pend ? pend_idx : (dz_req ? IW'(DZ_VEC) : exc_idx);
  wire [1:0] pop_m = mem_rdata[15:14];
  wire ret_ok   = (pop_m != M_BAD) && (pop_m >= m0);
  wire [15:0] vaddr = 16'(vec_r) << 2;

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = 16'h0;
    mem_wdata = 16'h0;
    case (st)
      S_PSHS: begin mem_we = 1'b1; mem_addr = sp0 - 16'd2; mem_wdata = opsw; end
      S_PSHP: begin mem_we = 1'b1; mem_addr = sp0 - 16'd4; mem_wdata = opc;  end
      S_VPC:  mem_addr = vaddr;
      S_VPS:  mem_addr = vaddr + 16'd2;
      S_POPP: mem_addr = sp0;
      S_POPS: mem_addr = sp0 + 16'd2;
      S_STW:  begin mem_we = 1'b1; mem_addr = stw_a; mem_wdata = stw_d; end
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {pc_r, psw_r, sp_r, sp0, opc, opsw, stw_a, stw_d} <= '0;
      {vec_r, pend_idx, m0, stw_m} <= '0;
      {pend, is_ret, faulted, fault_q, deny_q} <= '0;
    end else begin
      fault_q <= 1'b0;
      deny_q  <= 1'b0;
      if (idle && pend) pend <= 1'b0;
      if ((keep_d || keep_e) && pend_ok) begin
        pend     <= 1'b1;
        pend_idx <= keep_d ? IW'(DZ_VEC) : exc_idx;
      end
      if (start_x || start_r) begin
        sp0  <= cur_sp;
        opc  <= cur_pc;
        opsw <= cur_psw;
        m0   <= cur_psw[15:14];
      end
      case (st)
        S_IDLE: begin
          if (start_x) begin
            vec_r   <= take_idx;
            is_ret  <= 1'b0;
            faulted <= 1'b0;
            st      <= S_PSHS;
          end else if (start_r) begin
            is_ret  <= 1'b1;
            faulted <= 1'b0;
            st      <= S_POPP;
          end else if (start_s) begin
            if (st_block) deny_q <= 1'b1;
            else begin
              stw_a <= st_addr;
              stw_d <= st_data;
              stw_m <= cur_psw[15:14];
              st    <= S_STW;
            end
          end
        end
        S_PSHS: if (mem_rdy) st <= S_PSHP;
        S_PSHP: if (mem_rdy) st <= S_VPC;
        S_VPC:  if (mem_rdy) begin pc_r <= mem_rdata; st <= S_VPS; end
        S_VPS:  if (mem_rdy) begin
          psw_r <= (vec_r == IW'(FLT_VEC)) ? {2'b00, mem_rdata[13:0]} : mem_rdata;
          sp_r  <= sp0 - 16'd4;
          st    <= S_DONE;
        end
        S_POPP: if (mem_rdy) begin pc_r <= mem_rdata; st <= S_POPS; end
        S_POPS: if (mem_rdy) begin
          if (ret_ok) begin
            psw_r <= mem_rdata;
            sp_r  <= sp0 + 16'd4;
            st    <= S_DONE;
          end else begin
            fault_q <= 1'b1;
            vec_r   <= IW'(FLT_VEC);
            is_ret  <= 1'b0;
            faulted <= 1'b1;
            st      <= S_PSHS;
          end
        end
        S_DONE: st <= S_IDLE;
        S_STW:  if (mem_rdy) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign new_pc     = pc_r;
  assign new_psw    = psw_r;
  assign new_sp     = sp_r;
  assign upd        = (st == S_DONE);
  assign busy       = ~idle;
  assign priv_fault = fault_q;
  assign wr_denied  = deny_q;

  AST_RET_PRIV:   assert property (@(posedge clk) disable iff (!rst_n) (upd && is_ret) |-> (psw_r[15:14] != M_BAD && psw_r[15:14] >= m0)); // R4
  AST_FLT_KERNEL: assert property (@(posedge clk) disable iff (!rst_n) (upd && faulted) |-> psw_r[15:14] == 2'b00); // R5
  AST_ENTRY_SP:   assert property (@(posedge clk) disable iff (!rst_n) (upd && !is_ret) |-> sp_r == sp0 - 16'd4); // R2
  AST_VT_GUARD:   assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we && st == S_STW) |-> (stw_a >= VT_END || stw_m != M_USR)); // R6
  AST_UPD_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) upd |=> !upd); // R9
  AST_UPD_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) upd |-> busy); // R9
  AST_MEM_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
endmodule

// File: tb/test_trap_sequencer.sv
`timescale 1ns/1ps
module test_trap_sequencer;
  logic clk = 0, rst_n = 0;
  logic exc_req = 0, dz_req = 0, rti_req = 0, st_req = 0;
  logic [2:0] exc_idx = 0;
  logic [15:0] st_addr = 0, st_data = 0, cur_pc = 0, cur_psw = 0, cur_sp = 0;
  logic mem_req, mem_we, mem_rdy, upd, busy, priv_fault, wr_denied;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, new_pc, new_psw, new_sp;

  logic [15:0] mem [0:255];
  logic tbw = 0; logic [7:0] tba = 0; logic [15:0] tbd = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic stall_on = 0;
  int nchk = 0, nfail = 0, fcnt = 0, dcnt = 0;

  always #4 clk = ~clk;

  trap_sequencer i_trap_sequencer (.*);

  assign mem_rdy   = mem_req & (stall_on ? lfsr[0] : 1'b1);
  assign mem_rdata = mem[mem_addr[8:1]];

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (tbw) mem[tba] <= tbd;
    else if (mem_req && mem_we && mem_rdy) mem[mem_addr[8:1]] <= mem_wdata;
    if (priv_fault) fcnt <= fcnt + 1;
    if (wr_denied) dcnt <= dcnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] byte_a, input logic [15:0] d);
    tbw = 1; tba = byte_a[8:1]; tbd = d;
    @(negedge clk);
    tbw = 0;
  endtask

  task automatic wait_upd(input string tag);
    int n = 0;
    while (!upd && n < 400) begin @(negedge clk); n++; end
    if (!upd) chk(0, tag, 16'h0, 16'h1);
  endtask

  function automatic logic [15:0] vpc(input int i);
    return 16'h1000 + 16'(i) * 16'h10;
  endfunction
  function automatic logic [15:0] vpsw(input int i);
    return ((i % 2) ? 16'hC000 : 16'h4000) | 16'(i);
  endfunction

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog: actual %h expected %h", 16'h0, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !upd && !priv_fault && !wr_denied, "R9 reset flags", {12'h0, busy, upd, priv_fault, wr_denied}, 16'h0);
    chk(new_pc == 0 && new_psw == 0 && new_sp == 0, "R9 reset outputs", new_pc, 16'h0);

    for (int i = 0; i < 8; i++) begin
      poke(16'(4 * i), vpc(i));
      poke(16'(4 * i + 2), vpsw(i));
    end

    // R1 R2 R10: every vector, without and with memory wait states
    for (int s = 0; s < 2; s++) begin
      stall_on = (s == 1);
      for (int i = 0; i < 8; i++) begin
        logic [15:0] sp, epsw;
        sp = 16'h0100 + 16'(s * 16'h40);
        cur_sp = sp; cur_pc = 16'h5000 + 16'(i); cur_psw = 16'hC0F0 | 16'(i);
        exc_idx = 3'(i); exc_req = 1;
        @(negedge clk); exc_req = 0;
        wait_upd("R1 timeout");
        epsw = (i == 1) ? (vpsw(i) & 16'h3FFF) : vpsw(i);
        chk(busy, "R9 busy at upd", {15'h0, busy}, 16'h1);
        chk(new_pc == vpc(i), "R1 entry pc", new_pc, vpc(i));
        chk(new_psw == epsw, "R1 entry psw", new_psw, epsw);
        chk(new_sp == sp - 4, "R2 entry sp", new_sp, sp - 16'd4);
        chk(mem[(sp - 2) >> 1] == cur_psw, "R2 pushed psw", mem[(sp - 2) >> 1], cur_psw);
        chk(mem[(sp - 4) >> 1] == cur_pc, "R2 pushed pc", mem[(sp - 4) >> 1], cur_pc);
        @(negedge clk);
        chk(!upd && !busy, "R9 upd single cycle", {14'h0, upd, busy}, 16'h0);
      end
    end

    // R3 R4 R5: all current x restored mode pairs
    stall_on = 1;
    for (int cm = 0; cm < 4; cm++) begin
      for (int nm = 0; nm < 4; nm++) begin
        logic [15:0] sp, ppc, ppsw;
        bit ok;
        int f0;
        sp = 16'h0140;
        ppc = 16'h2000 + 16'(cm * 4 + nm);
        ppsw = {2'(nm), 14'h0} | 16'(cm * 4 + nm);
        poke(sp, ppc);
        poke(sp + 2, ppsw);
        cur_sp = sp; cur_pc = 16'h3000 + 16'(cm * 4 + nm); cur_psw = {2'(cm), 14'h0} | 16'h0020;
        ok = (nm != 2) && (nm >= cm);
        f0 = fcnt;
        rti_req = 1;
        @(negedge clk); rti_req = 0;
        wait_upd("R3 timeout");
        if (ok) begin
          chk(new_pc == ppc, "R3 popped pc", new_pc, ppc);
          chk(new_psw == ppsw, "R4 restored psw", new_psw, ppsw);
          chk(new_sp == sp + 4, "R3 popped sp", new_sp, sp + 16'd4);
          chk(fcnt == f0, "R4 no fault", 16'(fcnt - f0), 16'h0);
        end else begin
          chk(fcnt == f0 + 1, "R5 fault pulse", 16'(fcnt - f0), 16'h1);
          chk(new_pc == vpc(1), "R5 fault vector pc", new_pc, vpc(1));
          chk(new_psw == (vpsw(1) & 16'h3FFF), "R5 kernel mode", new_psw, vpsw(1) & 16'h3FFF);
          chk(new_sp == sp - 4, "R5 fault sp", new_sp, sp - 16'd4);
          chk(mem[(sp - 2) >> 1] == cur_psw, "R5 pushed mode unchanged", mem[(sp - 2) >> 1], cur_psw);
          chk(mem[(sp - 4) >> 1] == cur_pc, "R5 pushed pc", mem[(sp - 4) >> 1], cur_pc);
        end
        @(negedge clk);
      end
    end

    // R7 R8: divide-by-zero and general request together
    begin
      logic [15:0] sp1;
      cur_sp = 16'h0180; cur_pc = 16'h6000; cur_psw = 16'h4001;
      exc_idx = 3'd5; exc_req = 1; dz_req = 1;
      @(negedge clk); exc_req = 0; dz_req = 0;
      wait_upd("R7 timeout");
      chk(new_pc == vpc(2), "R7 dz first pc", new_pc, vpc(2));
      chk(new_psw == vpsw(2), "R7 dz first psw", new_psw, vpsw(2));
      cur_pc = new_pc; cur_psw = new_psw; cur_sp = new_sp; sp1 = new_sp;
      @(negedge clk);
      wait_upd("R8 timeout");
      chk(new_pc == vpc(5), "R8 held pc", new_pc, vpc(5));
      chk(new_sp == sp1 - 4, "R8 held sp", new_sp, sp1 - 16'd4);
      chk(mem[(sp1 - 2) >> 1] == vpsw(2), "R8 held pushed psw", mem[(sp1 - 2) >> 1], vpsw(2));
      chk(mem[(sp1 - 4) >> 1] == vpc(2), "R8 held pushed pc", mem[(sp1 - 4) >> 1], vpc(2));
      @(negedge clk);
    end

    // R8: request while busy
    begin
      logic [15:0] sp1;
      cur_sp = 16'h01C0; cur_pc = 16'h7000; cur_psw = 16'hC000;
      exc_idx = 3'd3; exc_req = 1;
      @(negedge clk); exc_req = 0;
      @(negedge clk); @(negedge clk);
      chk(busy, "R8 busy during sequence", {15'h0, busy}, 16'h1);
      exc_idx = 3'd4; exc_req = 1;
      @(negedge clk); exc_req = 0;
      wait_upd("R8 timeout a");
      chk(new_pc == vpc(3), "R8 first pc", new_pc, vpc(3));
      cur_pc = new_pc; cur_psw = new_psw; cur_sp = new_sp; sp1 = new_sp;
      @(negedge clk);
      wait_upd("R8 timeout b");
      chk(new_pc == vpc(4), "R8 second pc", new_pc, vpc(4));
      chk(new_psw == vpsw(4), "R8 second psw", new_psw, vpsw(4));
      chk(new_sp == sp1 - 4, "R8 second sp", new_sp, sp1 - 16'd4);
      @(negedge clk);
    end

    // R6: stores by mode and address
    for (int m = 0; m < 3; m++) begin
      for (int a = 0; a < 4; a++) begin
        logic [15:0] ad, old, dat;
        logic [1:0] md;
        bit blk;
        int d0;
        md = (m == 2) ? 2'b11 : 2'(m);
        ad = (a == 0) ? 16'h0000 : (a == 1) ? 16'h001E : (a == 2) ? 16'h0020 : 16'h0060;
        dat = 16'hA500 | 16'(m * 4 + a);
        old = mem[ad >> 1];
        blk = (md == 2'b11) && (ad < 16'h0020);
        d0 = dcnt;
        cur_psw = {md, 14'h0};
        st_addr = ad; st_data = dat; st_req = 1;
        @(negedge clk); st_req = 0;
        @(negedge clk);
        while (busy) @(negedge clk);
        chk(mem[ad >> 1] == (blk ? old : dat), "R6 store result", mem[ad >> 1], blk ? old : dat);
        chk((dcnt - d0) == (blk ? 1 : 0), "R6 denied pulse", 16'(dcnt - d0), blk ? 16'h1 : 16'h0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule